// File: doc/BRIEF.md
# Decimal Address Modifier With Limits

This block takes a storage address of several decimal digits, each digit carried as a two-out-of-five code, and applies one modification per step. The modification can add one, subtract one, or copy the address unchanged. Carries and borrows ripple across all digits in the same cycle, and the result is coded back into two-out-of-five. The block also checks each input digit for a legal code and flags an address that runs past either end of storage.

The modification is chosen by three control latches: add-one, subtract-one and modify-by-zero. Separate request pulses set them, and one shared request clears them. The latches have a fixed set/clear priority, so that a set and a clear arriving together never leave a latch in doubt. The top-limit check has an exemption for accesses from the manual console and for I/O that runs to the end of storage. Such an access may touch the last location without raising an error.

Top module: `decAddrModifier`

## Requirements
- R1: Digit value d (0..9) is coded as the d-th pair of bit positions (i,j), i<j, taken in lexicographic order: 0 is bits 0 and 1, 1 is bits 0 and 2, 3 is bits 0 and 4, 4 is bits 1 and 2, and 9 is bits 3 and 4. Digit k of the address bus sits at bits 5k+4..5k, with digit 0 the least significant. Every output digit after a valid step carries exactly two set bits.
- R2: On a step where any input digit does not have exactly two bits set (including none), validErr is 1 on the next cycle. addrOut then equals the input unchanged and addrCheck is 0.
- R3: On a step in add-one mode, addrOut is (input + 1) mod 10^DIGITS, with the carry rippling through every digit.
- R4: On a step in subtract-one mode, addrOut is (input - 1) mod 10^DIGITS. When the input is 00000, addrCheck is 1.
- R5: On a step in modify-by-zero mode or in idle mode, addrOut equals the input and addrCheck is 0.
- R6: On a step in add-one mode, addrCheck is 1 when the input is above MAX_ADDR. It is also 1 when the input equals MAX_ADDR and exempt is 0.
- R7: When exempt is 1, an add-one step from exactly MAX_ADDR raises no addrCheck. The result is still MAX_ADDR + 1.
- R8: modeSel reports the active latch as 1 for add-one, 2 for subtract-one, 3 for modify-by-zero and 0 for idle. Add-one has priority over subtract-one, and subtract-one over modify-by-zero. A set request for one latch clears the other latches. The new mode shows one cycle after the request.
- R9: A modify-by-zero request is ignored in any cycle where an add-one or subtract-one request is also active.
- R10: While the modify-by-zero request is active, nothing clears the modify-by-zero latch. A zero request together with the clear request leaves the mode at 3.
- R11: A clear request, with no zero request in the same cycle, returns all latches to idle.
- R12: addrOut, validErr and addrCheck change only on the cycle after a step. They hold while step is 0.
- R13: A synchronous reset sets modeSel to 0, addrOut to all-zero digits, and validErr and addrCheck to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| setPlus | input | 1 | Request to select add-one |
| setMinus | input | 1 | Request to select subtract-one |
| setZero | input | 1 | Request to select modify-by-zero |
| clrMode | input | 1 | Request to clear the mode latches |
| step | input | 1 | Apply the current modification to addrIn |
| exempt | input | 1 | Console or end-of-storage I/O access; excuses the last location |
| addrIn | input | 5*DIGITS | Address in, two-out-of-five per digit |
| addrOut | output | 5*DIGITS | Modified address, registered |
| modeSel | output | 2 | Active mode |
| validErr | output | 1 | Input digit code invalid on the last step |
| addrCheck | output | 1 | Address out of range on the last step |

## Verification
A mode latch left in a wrong state appears on modeSel one cycle after the request that caused it. It also shows on the next step, as a wrong address or a missing or extra range error. A faulty carry or borrow chain appears only on inputs that end in nines or zeros, so the sweeps include every trailing-nine and trailing-zero boundary. Stepping in every mode across the address range exposes a bad comparison against the top limit at the first address past it. A bad code table shows on any digit that passes through the affected value.

// File: rtl/addrModPkg.sv
package addrModPkg;

  localparam int DIGIT_W = 5;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_PLUS  = 2'd1,
    MODE_MINUS = 2'd2,
    MODE_ZERO  = 2'd3
  } modMode_e;

  typedef struct packed {
    logic step;
    logic incr;
    logic decr;
    logic exempt;
  } modStrobe_t;

  // Value v maps to the v-th bit pair (i<j) in lexicographic order.
  function automatic logic [DIGIT_W-1:0] encDigit(input logic [3:0] v);
    logic [DIGIT_W-1:0] code;
    int k;
    code = '0;
    k = 0;
    for (int i = 0; i < DIGIT_W; i++) begin
      for (int j = i + 1; j < DIGIT_W; j++) begin
        if (k == int'(v)) begin
          code[i] = 1'b1;
          code[j] = 1'b1;
        end
        k++;
      end
    end
    return code;
  endfunction

  function automatic logic [3:0] decDigit(input logic [DIGIT_W-1:0] code);
    logic [3:0] val;
    val = 4'd0;
    for (int v = 0; v < 10; v++) begin
      if (encDigit(4'(v)) == code) val = 4'(v);
    end
    return val;
  endfunction

endpackage

// File: rtl/addrModCtl.sv
module addrModCtl
  import addrModPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       setPlus,
  input  logic       setMinus,
  input  logic       setZero,
  input  logic       clrMode,
  input  logic       step,
  input  logic       exempt,
  output modStrobe_t strobe,
  output modMode_e   modeSel
);

  logic plusQ, minusQ, zeroQ;
  logic plusN, minusN, zeroN;
  logic minusSetEff, zeroSetEff;

  // Priority among the set requests: add-one, then subtract-one, then zero.
  assign minusSetEff = setMinus & ~setPlus;
  assign zeroSetEff  = setZero & ~setPlus & ~setMinus;

  always_comb begin
    // Add-one latch: a set beats any clear arriving at the same time.
    if (setPlus)                              plusN = 1'b1;
    else if (minusSetEff | zeroSetEff | clrMode) plusN = 1'b0;
    else                                      plusN = plusQ;

    if (minusSetEff)                          minusN = 1'b1;
    else if (setPlus | zeroSetEff | clrMode)  minusN = 1'b0;
    else                                      minusN = minusQ;

    // Zero latch: any zero request holds off a clear, even one it loses.
    if (zeroSetEff)                           zeroN = 1'b1;
    else if (setZero)                         zeroN = zeroQ;
    else if (clrMode | setPlus | setMinus)    zeroN = 1'b0;
    else                                      zeroN = zeroQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      plusQ  <= 1'b0;
      minusQ <= 1'b0;
      zeroQ  <= 1'b0;
    end else begin
      plusQ  <= plusN;
      minusQ <= minusN;
      zeroQ  <= zeroN;
    end
  end

  always_comb begin
    if (plusQ)       modeSel = MODE_PLUS;
    else if (minusQ) modeSel = MODE_MINUS;
    else if (zeroQ)  modeSel = MODE_ZERO;
    else             modeSel = MODE_IDLE;
  end

  assign strobe.step   = step;
  assign strobe.incr   = (modeSel == MODE_PLUS);
  assign strobe.decr   = (modeSel == MODE_MINUS);
  assign strobe.exempt = exempt;

endmodule

// File: rtl/addrModPath.sv
module addrModPath
  import addrModPkg::*;
#(
  parameter int DIGITS   = 5,
  parameter int MAX_ADDR = 39999
) (
  input  logic                      clk,
  input  logic                      rst,
  input  modStrobe_t                strobe,
  input  logic [DIGITS*DIGIT_W-1:0] addrIn,
  output logic [DIGITS*DIGIT_W-1:0] addrOut,
  output logic                      validErr,
  output logic                      addrCheck
);

  localparam int ADDR_W = DIGITS * DIGIT_W;
  localparam logic [DIGIT_W-1:0] ZERO_CODE = encDigit(4'd0);
  localparam logic [ADDR_W-1:0] RESET_ADDR = {DIGITS{ZERO_CODE}};

  logic [3:0]        dVal  [DIGITS];
  logic [3:0]        nVal  [DIGITS];
  logic [DIGITS-1:0] dOk;
  logic [DIGITS:0]   carry;
  logic [DIGITS:0]   borrow;
  logic [ADDR_W-1:0] newAddr;
  logic [31:0]       inValue;
  logic              allOk, incCheck, decCheck;

  assign carry[0]  = strobe.incr;
  assign borrow[0] = strobe.decr;

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic [DIGIT_W-1:0] code;
    assign code    = addrIn[g*DIGIT_W +: DIGIT_W];
    assign dOk[g]  = ($countones(code) == 2);
    assign dVal[g] = decDigit(code);

    always_comb begin
      nVal[g] = dVal[g];
      if (carry[g])       nVal[g] = (dVal[g] == 4'd9) ? 4'd0 : dVal[g] + 4'd1;
      else if (borrow[g]) nVal[g] = (dVal[g] == 4'd0) ? 4'd9 : dVal[g] - 4'd1;
    end

    assign carry[g+1]  = carry[g]  & (dVal[g] == 4'd9);
    assign borrow[g+1] = borrow[g] & (dVal[g] == 4'd0);
    assign newAddr[g*DIGIT_W +: DIGIT_W] = encDigit(nVal[g]);
  end

  assign allOk = &dOk;

  always_comb begin
    inValue = 32'd0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      inValue = inValue * 32'd10 + 32'(dVal[i]);
    end
  end

  assign incCheck = strobe.incr &
                    ((inValue > 32'(MAX_ADDR)) |
                     ((inValue == 32'(MAX_ADDR)) & ~strobe.exempt));
  assign decCheck = strobe.decr & (inValue == 32'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addrOut   <= RESET_ADDR;
      validErr  <= 1'b0;
      addrCheck <= 1'b0;
    end else if (strobe.step) begin
      addrOut   <= allOk ? newAddr : addrIn;
      validErr  <= ~allOk;
      addrCheck <= allOk & (incCheck | decCheck);
    end
  end

endmodule

// File: rtl/decAddrModifier.sv
module decAddrModifier
  import addrModPkg::*;
#(
  parameter int DIGITS   = 5,
  parameter int MAX_ADDR = 39999
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      setPlus,
  input  logic                      setMinus,
  input  logic                      setZero,
  input  logic                      clrMode,
  input  logic                      step,
  input  logic                      exempt,
  input  logic [DIGITS*DIGIT_W-1:0] addrIn,
  output logic [DIGITS*DIGIT_W-1:0] addrOut,
  output logic [1:0]                modeSel,
  output logic                      validErr,
  output logic                      addrCheck
);

  modStrobe_t strobe;
  modMode_e   mode;

  addrModCtl uCtl (
    .clk      (clk),
    .rst      (rst),
    .setPlus  (setPlus),
    .setMinus (setMinus),
    .setZero  (setZero),
    .clrMode  (clrMode),
    .step     (step),
    .exempt   (exempt),
    .strobe   (strobe),
    .modeSel  (mode)
  );

  addrModPath #(.DIGITS(DIGITS), .MAX_ADDR(MAX_ADDR)) uPath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .addrIn    (addrIn),
    .addrOut   (addrOut),
    .validErr  (validErr),
    .addrCheck (addrCheck)
  );

  assign modeSel = mode;

endmodule

// File: rtl/decAddrModifierChk.sv
module decAddrModifierChk
  import addrModPkg::*;
#(
  parameter int DIGITS = 5
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      setPlus,
  input logic                      setMinus,
  input logic                      setZero,
  input logic                      step,
  input logic [DIGITS*DIGIT_W-1:0] addrIn,
  input logic [DIGITS*DIGIT_W-1:0] addrOut,
  input logic [1:0]                modeSel,
  input logic                      validErr,
  input logic                      addrCheck
);

  localparam logic [DIGITS*DIGIT_W-1:0] ZERO_ADDR = {DIGITS{encDigit(4'd0)}};

  logic inBad, outGood;
  always_comb begin
    inBad   = 1'b0;
    outGood = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if ($countones(addrIn[i*DIGIT_W +: DIGIT_W]) != 2)  inBad   = 1'b1;
      if ($countones(addrOut[i*DIGIT_W +: DIGIT_W]) != 2) outGood = 1'b0;
    end
  end

  p_code_out_r1: assert property (@(posedge clk) disable iff (rst)
    !validErr |-> outGood);

  p_invalid_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (step && inBad) |=> (validErr && !addrCheck));

  p_floor_check_r4: assert property (@(posedge clk) disable iff (rst)
    (step && modeSel == 2'd2 && addrIn == ZERO_ADDR) |=> addrCheck);

  p_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !inBad && (modeSel == 2'd3 || modeSel == 2'd0))
      |=> (!addrCheck && addrOut == $past(addrIn)));

  p_plus_wins_r9: assert property (@(posedge clk) disable iff (rst)
    setPlus |=> (modeSel == 2'd1));

  p_zero_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (setZero && !setPlus && !setMinus) |=> (modeSel == 2'd3));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(addrOut) && $stable(validErr) && $stable(addrCheck)));

endmodule

bind decAddrModifier decAddrModifierChk #(.DIGITS(DIGITS)) uChk (
  .clk       (clk),
  .rst       (rst),
  .setPlus   (setPlus),
  .setMinus  (setMinus),
  .setZero   (setZero),
  .step      (step),
  .addrIn    (addrIn),
  .addrOut   (addrOut),
  .modeSel   (modeSel),
  .validErr  (validErr),
  .addrCheck (addrCheck)
);

// File: tb/decAddrModifier_test.sv
module decAddrModifier_test;

  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 5;
  localparam int TOP = 39999;
  localparam int SPAN = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic setPlus = 0, setMinus = 0, setZero = 0, clrMode = 0, step = 0, exempt = 0;
  logic [NDIG*5-1:0] addrIn = '0;
  logic [NDIG*5-1:0] addrOut;
  logic [1:0] modeSel;
  logic validErr, addrCheck;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decAddrModifier #(.DIGITS(NDIG), .MAX_ADDR(TOP)) uut (
    .clk(clk), .rst(rst), .setPlus(setPlus), .setMinus(setMinus),
    .setZero(setZero), .clrMode(clrMode), .step(step), .exempt(exempt),
    .addrIn(addrIn), .addrOut(addrOut), .modeSel(modeSel),
    .validErr(validErr), .addrCheck(addrCheck)
  );

  function automatic logic [4:0] codeOf(input int d);
    logic [4:0] r = '0;
    int k = 0;
    for (int i = 0; i < 5; i++)
      for (int j = i + 1; j < 5; j++) begin
        if (k == d) r = 5'((1 << i) | (1 << j));
        k++;
      end
    return r;
  endfunction

  function automatic logic [NDIG*5-1:0] encAddr(input int a);
    logic [NDIG*5-1:0] r;
    int v = a;
    for (int i = 0; i < NDIG; i++) begin
      r[i*5 +: 5] = codeOf(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setMode(input bit p, input bit m, input bit z, input bit c);
    @(negedge clk);
    setPlus = p; setMinus = m; setZero = z; clrMode = c;
    @(negedge clk);
    setPlus = 0; setMinus = 0; setZero = 0; clrMode = 0;
  endtask

  task automatic doStep(input logic [NDIG*5-1:0] code, input bit ex);
    @(negedge clk);
    addrIn = code; exempt = ex; step = 1;
    @(negedge clk);
    step = 0;
  endtask

  // mode: 1 add-one, 2 subtract-one, 3 zero
  task automatic stepCheck(input int a, input int mode, input bit ex, input string req);
    int expA;
    bit expC;
    doStep(encAddr(a), ex);
    if (mode == 1) begin
      expA = (a + 1) % SPAN;
      expC = (a > TOP) || (a == TOP && !ex);
    end else if (mode == 2) begin
      expA = (a + SPAN - 1) % SPAN;
      expC = (a == 0);
    end else begin
      expA = a;
      expC = 0;
    end
    chk(addrOut == encAddr(expA), req, longint'(addrOut), longint'(encAddr(expA)));
    chk(addrCheck == expC, {req, " check"}, longint'(addrCheck), longint'(expC));
    chk(validErr == 0, {req, " valid"}, longint'(validErr), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R13 reset state
    chk(modeSel == 0, "R13 mode", modeSel, 0);
    chk(addrOut == encAddr(0), "R13 addr", longint'(addrOut), longint'(encAddr(0)));
    chk(!validErr && !addrCheck, "R13 flags", {validErr, addrCheck}, 0);

    // R1 code table: every digit value in every position through zero mode
    setMode(0, 0, 1, 0);
    chk(modeSel == 3, "R8 zero select", modeSel, 3);
    for (int d = 0; d < 10; d++) stepCheck(d * 11111, 3, 0, "R1 code");

    // R8 / R9 / R10 / R11 latch behaviour
    setMode(1, 0, 1, 0);
    chk(modeSel == 1, "R9 zero ignored with plus", modeSel, 1);
    setMode(0, 0, 0, 1);
    chk(modeSel == 0, "R11 clear", modeSel, 0);
    stepCheck(1234, 3, 0, "R5 idle copy");
    setMode(0, 0, 1, 1);
    chk(modeSel == 3, "R10 zero with clear", modeSel, 3);
    setMode(0, 0, 0, 1);
    setMode(0, 0, 0, 0);
    chk(modeSel == 0, "R11 clear zero", modeSel, 0);
    setMode(0, 1, 1, 0);
    chk(modeSel == 2, "R9 zero ignored with minus", modeSel, 2);
    setMode(1, 1, 0, 1);
    chk(modeSel == 1, "R8 plus priority", modeSel, 1);
    setMode(0, 1, 0, 0);
    chk(modeSel == 2, "R8 minus clears plus", modeSel, 2);

    // R4 subtract sweep and boundaries
    for (int a = 0; a < SPAN; a += 37) stepCheck(a, 2, 0, "R4 dec");
    stepCheck(0, 2, 0, "R4 floor");
    stepCheck(10000, 2, 0, "R4 borrow");
    stepCheck(99999, 2, 0, "R4 top digit");

    // R3 / R6 / R7 add sweep and boundaries
    setMode(1, 0, 0, 0);
    for (int a = 1; a < SPAN; a += 37) stepCheck(a, 1, 0, "R3 inc");
    stepCheck(9999, 1, 0, "R3 carry");
    stepCheck(99999, 1, 0, "R3 wrap");
    stepCheck(TOP - 1, 1, 0, "R6 below top");
    stepCheck(TOP, 1, 0, "R6 at top");
    stepCheck(TOP + 1, 1, 0, "R6 above top");
    stepCheck(TOP, 1, 1, "R7 exempt top");
    stepCheck(TOP + 1, 1, 1, "R7 exempt above");

    // R12 hold while step is low
    @(negedge clk);
    addrIn = encAddr(777);
    @(negedge clk);
    chk(addrOut == encAddr(TOP + 2), "R12 hold", longint'(addrOut), longint'(encAddr(TOP + 2)));
    chk(addrCheck == 1, "R12 hold check", addrCheck, 1);

    // R2 invalid codes at every position
    for (int p = 0; p < NDIG; p++)
      for (int c = 0; c < 32; c++) begin
        if ($countones(c) != 2) begin
          logic [NDIG*5-1:0] bad;
          bad = encAddr(TOP);
          bad[p*5 +: 5] = 5'(c);
          doStep(bad, 0);
          chk(validErr == 1, "R2 flag", validErr, 1);
          chk(addrOut == bad, "R2 pass", longint'(addrOut), longint'(bad));
          chk(addrCheck == 0, "R2 no check", addrCheck, 0);
        end
      end

    // R5 zero mode sweep
    setMode(0, 0, 1, 0);
    for (int a = 5; a < SPAN; a += 37) stepCheck(a, 3, 0, "R5 zero");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule